// File: doc/BRIEF.md
# Bus Idle and Clock-Low Timeout Monitor

This block watches the two wires of a two-wire serial bus and counts prescaled clock ticks, to catch two faults: a bus that is claimed as busy while both lines rest high for too long, and a clock line held low for too long. Each watch has its own encoded length selector, and a selector value of zero turns that watch off. When a watch expires it raises its own sticky flag. The flag stays set until the controller pulses the matching clear input.

The bus idle watch can also release the bus state. With the go-idle option set, an idle expiry also produces a one-cycle force-idle pulse, which tells the transfer controller that the bus is free and a new transfer may start.

Each watch is a small state machine with three states. WS_IDLE means the watch is not counting, either because its condition is absent or because the watch is off. WS_RUN means the condition holds and ticks are being counted. WS_SPENT means the watch has expired and waits for the condition to end.

The transitions are as follows. WS_IDLE goes to WS_RUN when the condition appears with the watch on; a tick in that same cycle counts as the first tick. WS_RUN goes to WS_SPENT on the tick that reaches the selected length, and this transition is the expiry. WS_RUN goes back to WS_IDLE when the condition ends or the watch is turned off, and the count is lost. WS_SPENT goes back to WS_IDLE when the condition ends or the watch is turned off.

Top module: `bus_timeout_watch`

## Requirements
- R1: After reset, idle_flag, low_flag and force_idle are all 0.
- R2: The idle selector idle_sel picks the idle length: 0 turns the watch off, and 1, 2 and 3 select 40, 80 and 160 ticks.
- R3: The clock-low selector low_sel picks the clock-low length: 1 selects 40 ticks, 2 selects 80, 3 selects 160, 4 selects 320 and 5 selects 1024. The values 0, 6 and 7 turn the watch off.
- R4: The idle watch counts only while bus_busy, scl_in and sda_in are all 1. Any one of them going to 0 discards the count.
- R5: The clock-low watch counts while scl_in is 0, whatever bus_busy is. scl_in returning to 1 discards the count.
- R6: A flag becomes 1 in the cycle after the clock edge that takes in the tick reaching the selected length. It stays 1 until its clear input is sampled high. A set and a clear in the same cycle leave the flag at 1.
- R7: Each unbroken stretch of a condition produces at most one expiry. After an expiry, that watch does not count again until its condition has ended.
- R8: With go_idle_en at 1, force_idle is a one-cycle pulse in the same cycle that idle_flag is set by an idle expiry. With go_idle_en at 0, force_idle stays 0.
- R9: A watch advances only on cycles where tick is 1. Cycles without a tick do not count toward any length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Prescaled timing tick, one cycle wide |
| scl_in | input | 1 | Sampled clock line |
| sda_in | input | 1 | Sampled data line |
| bus_busy | input | 1 | Bus is currently claimed |
| idle_sel | input | 2 | Idle timeout length code |
| low_sel | input | 3 | Clock-low timeout length code |
| go_idle_en | input | 1 | Idle expiry also releases the bus state |
| idle_flag_clr | input | 1 | Clear pulse for idle_flag |
| low_flag_clr | input | 1 | Clear pulse for low_flag |
| idle_flag | output | 1 | Sticky bus idle timeout flag |
| low_flag | output | 1 | Sticky clock-low timeout flag |
| force_idle | output | 1 | One-cycle pulse declaring the bus idle |

## Verification
The two functions that can meet in one cycle are the setting of a sticky flag by an expiry and its clearing by the clear input. The bench provokes this by holding the clear input high for the whole of an idle expiry. It then judges that the flag reads 1 in the cycle after the expiring tick, and 0 one cycle later.

The bench's reference model resolves the same collision on its own terms. Every cycle it compares both flags and the force-idle pulse against that model, including across changes of selector, stretches of sparse ticks and restarts caused by line changes.

// File: rtl/bus_to_pkg.sv
package bus_to_pkg;

    typedef enum logic [1:0] {
        WS_IDLE  = 2'd0,
        WS_RUN   = 2'd1,
        WS_SPENT = 2'd2
    } watch_state_t;

    // Idle length: code 0 is off, each further code doubles the base length.
    function automatic int unsigned idle_len(input logic [1:0] code,
                                             input int unsigned base);
        int unsigned len;
        unique case (code)
            2'd1:    len = base;
            2'd2:    len = base * 2;
            2'd3:    len = base * 4;
            default: len = 0;
        endcase
        return len;
    endfunction

    // Clock-low length: codes 1..4 double the base, code 5 is the long limit,
    // and the remaining codes are off.
    function automatic int unsigned low_len(input logic [2:0] code,
                                            input int unsigned base,
                                            input int unsigned long_len);
        int unsigned len;
        unique case (code)
            3'd1:    len = base;
            3'd2:    len = base * 2;
            3'd3:    len = base * 4;
            3'd4:    len = base * 8;
            3'd5:    len = long_len;
            default: len = 0;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/to_watcher.sv
module to_watcher
    import bus_to_pkg::*;
#(
    parameter int CNT_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             cond,
    input  logic [CNT_W-1:0] limit,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    watch_state_t     state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             armed;
    logic             reach;

    assign armed = cond && (limit != '0);
    assign reach = (cnt_q + ONE) >= limit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= WS_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Next state and count
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            WS_IDLE: begin
                if (armed) begin
                    state_d = WS_RUN;
                    cnt_d   = tick ? ONE : '0;
                end
            end
            WS_RUN: begin
                if (!armed) begin
                    state_d = WS_IDLE;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (reach) begin
                        state_d = WS_SPENT;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + ONE;
                    end
                end
            end
            WS_SPENT: begin
                if (!armed) begin
                    state_d = WS_IDLE;
                end
            end
            default: begin
                state_d = WS_IDLE;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        expire = (state_q == WS_RUN) && armed && tick && reach;
    end

    // R7: an expiry is never followed straight away by another one
    a_r7_single_fire: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire);

    // R9: an expiry happens only in a tick cycle
    a_r9_tick_only: assert property (@(posedge clk) disable iff (!rst_n)
        expire |-> tick);

    // R7: once spent, the watch stays spent while its condition holds
    a_r7_no_rearm: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == WS_SPENT && armed) |=> (state_q == WS_SPENT));

endmodule

// File: rtl/to_flag.sv
module to_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    // R6: a flag only drops through its clear input
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);

    // R6: a set wins over a clear in the same cycle
    a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set |=> flag);

endmodule

// File: rtl/bus_timeout_watch.sv
module bus_timeout_watch
    import bus_to_pkg::*;
#(
    parameter int unsigned BASE_TICKS = 40,
    parameter int unsigned LONG_TICKS = 1024
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic       bus_busy,
    input  logic [1:0] idle_sel,
    input  logic [2:0] low_sel,
    input  logic       go_idle_en,
    input  logic       idle_flag_clr,
    input  logic       low_flag_clr,
    output logic       idle_flag,
    output logic       low_flag,
    output logic       force_idle
);

    localparam int unsigned MAX_LEN = (LONG_TICKS > BASE_TICKS * 8) ?
                                      LONG_TICKS : BASE_TICKS * 8;
    localparam int CNT_W = $clog2(MAX_LEN + 1);

    logic             idle_cond, low_cond;
    logic [CNT_W-1:0] idle_limit, low_limit;
    logic             idle_fire, low_fire;

    assign idle_cond  = bus_busy && scl_in && sda_in;
    assign low_cond   = !scl_in;
    assign idle_limit = CNT_W'(idle_len(idle_sel, BASE_TICKS));
    assign low_limit  = CNT_W'(low_len(low_sel, BASE_TICKS, LONG_TICKS));

    to_watcher #(.CNT_W(CNT_W)) u_idle_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .cond   (idle_cond),
        .limit  (idle_limit),
        .expire (idle_fire)
    );

    to_watcher #(.CNT_W(CNT_W)) u_low_watch (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .cond   (low_cond),
        .limit  (low_limit),
        .expire (low_fire)
    );

    to_flag u_idle_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (idle_fire),
        .clr   (idle_flag_clr),
        .flag  (idle_flag)
    );

    to_flag u_low_flag (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (low_fire),
        .clr   (low_flag_clr),
        .flag  (low_flag)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            force_idle <= 1'b0;
        end else begin
            force_idle <= idle_fire && go_idle_en;
        end
    end

    // R8: the release pulse always comes with the idle flag
    a_r8_force_with_flag: assert property (@(posedge clk) disable iff (!rst_n)
        force_idle |-> idle_flag);

    // R8: the release pulse requires the option to have been on
    a_r8_force_gated: assert property (@(posedge clk) disable iff (!rst_n)
        force_idle |-> $past(go_idle_en));

    // R8: the release pulse lasts a single cycle
    a_r8_force_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        force_idle |=> !force_idle);

    // R3: the clock-low watch never expires on an off code
    a_r3_low_codes: assert property (@(posedge clk) disable iff (!rst_n)
        low_fire |-> (low_sel >= 3'd1 && low_sel <= 3'd5));

    // R4: the idle watch expires only with the bus claimed and both lines high
    a_r4_idle_cond: assert property (@(posedge clk) disable iff (!rst_n)
        idle_fire |-> (bus_busy && scl_in && sda_in));

endmodule

// File: tb/tb_bus_timeout_watch.sv
module tb_bus_timeout_watch;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       scl_in = 1'b1;
    logic       sda_in = 1'b1;
    logic       bus_busy = 1'b0;
    logic [1:0] idle_sel = 2'd0;
    logic [2:0] low_sel = 3'd0;
    logic       go_idle_en = 1'b0;
    logic       idle_flag_clr = 1'b0;
    logic       low_flag_clr = 1'b0;
    logic       idle_flag, low_flag, force_idle;

    int    checks = 0;
    int    errors = 0;
    bit    done = 1'b0;
    string tag = "R1";
    int    tick_div = 1;
    int    phase_cyc = 0;

    // reference model state
    int m_idle_cnt = 0, m_low_cnt = 0;
    bit m_idle_spent = 0, m_low_spent = 0;
    bit m_idle_flag = 0, m_low_flag = 0, m_force = 0;

    bus_timeout_watch dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .tick          (tick),
        .scl_in        (scl_in),
        .sda_in        (sda_in),
        .bus_busy      (bus_busy),
        .idle_sel      (idle_sel),
        .low_sel       (low_sel),
        .go_idle_en    (go_idle_en),
        .idle_flag_clr (idle_flag_clr),
        .low_flag_clr  (low_flag_clr),
        .idle_flag     (idle_flag),
        .low_flag      (low_flag),
        .force_idle    (force_idle)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int idle_ticks(input logic [1:0] s);
        case (s)
            2'd1: return 40;
            2'd2: return 80;
            2'd3: return 160;
            default: return 0;
        endcase
    endfunction

    function automatic int low_ticks(input logic [2:0] s);
        case (s)
            3'd1: return 40;
            3'd2: return 80;
            3'd3: return 160;
            3'd4: return 320;
            3'd5: return 1024;
            default: return 0;
        endcase
    endfunction

    // behavioural reference, advanced on every rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_idle_cnt = 0; m_low_cnt = 0;
            m_idle_spent = 0; m_low_spent = 0;
            m_idle_flag = 0; m_low_flag = 0; m_force = 0;
        end else begin
            bit fi, fl;
            fi = 0; fl = 0;
            if (!(bus_busy && scl_in && sda_in) || idle_ticks(idle_sel) == 0) begin
                m_idle_cnt = 0; m_idle_spent = 0;
            end else if (!m_idle_spent && tick) begin
                m_idle_cnt++;
                if (m_idle_cnt >= idle_ticks(idle_sel)) begin
                    fi = 1; m_idle_spent = 1; m_idle_cnt = 0;
                end
            end
            if (scl_in || low_ticks(low_sel) == 0) begin
                m_low_cnt = 0; m_low_spent = 0;
            end else if (!m_low_spent && tick) begin
                m_low_cnt++;
                if (m_low_cnt >= low_ticks(low_sel)) begin
                    fl = 1; m_low_spent = 1; m_low_cnt = 0;
                end
            end
            m_idle_flag = fi ? 1'b1 : (idle_flag_clr ? 1'b0 : m_idle_flag);
            m_low_flag  = fl ? 1'b1 : (low_flag_clr ? 1'b0 : m_low_flag);
            m_force     = fi && go_idle_en;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t",
                     req, what, act, exp, $time);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(tag, "model idle_flag", idle_flag, m_idle_flag);
            chk(tag, "model low_flag", low_flag, m_low_flag);
            chk(tag, "model force_idle", force_idle, m_force);
        end
    end

    task automatic run(input int n);
        for (int i = 0; i < n; i++) begin
            tick = ((phase_cyc % tick_div) == 0);
            phase_cyc++;
            @(negedge clk);
        end
    endtask

    task automatic new_phase(input string t, input int div);
        tag = t;
        tick_div = div;
        phase_cyc = 0;
    endtask

    task automatic clear_both;
        idle_flag_clr = 1'b1;
        low_flag_clr = 1'b1;
        run(1);
        idle_flag_clr = 1'b0;
        low_flag_clr = 1'b0;
    endtask

    task automatic summary;
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "reset idle_flag", idle_flag, 1'b0);
        chk("R1", "reset low_flag", low_flag, 1'b0);
        chk("R1", "reset force_idle", force_idle, 1'b0);
        rst_n = 1'b1;
        run(5);

        // R2: idle length 40 at code 1
        new_phase("R2", 1);
        bus_busy = 1'b1; scl_in = 1'b1; sda_in = 1'b1; idle_sel = 2'd1;
        run(39);
        chk("R2", "idle code1 before 40", idle_flag, 1'b0);
        run(1);
        chk("R2", "idle code1 at 40", idle_flag, 1'b1);
        chk("R8", "no force when option off", force_idle, 1'b0);

        // R7: no second expiry while the condition lasts
        new_phase("R7", 1);
        clear_both();
        run(200);
        chk("R7", "no rearm while held", idle_flag, 1'b0);

        // R4: a short data-line dip restarts the count
        new_phase("R4", 1);
        sda_in = 1'b0; run(1); sda_in = 1'b1;
        run(30);
        sda_in = 1'b0; run(1); sda_in = 1'b1;
        run(39);
        chk("R4", "restart after dip", idle_flag, 1'b0);
        bus_busy = 1'b0; run(1); bus_busy = 1'b1;
        run(39);
        chk("R4", "restart after busy drop", idle_flag, 1'b0);
        run(1);
        chk("R4", "expiry after clean stretch", idle_flag, 1'b1);
        bus_busy = 1'b0;
        run(50);
        chk("R4", "no count when not busy", idle_flag, 1'b1);
        clear_both();
        run(50);
        chk("R4", "cleared, not busy", idle_flag, 1'b0);

        // R8: release pulse at codes 2 and 3
        new_phase("R8", 1);
        go_idle_en = 1'b1; idle_sel = 2'd2; bus_busy = 1'b1;
        run(79);
        chk("R8", "code2 before 80", force_idle, 1'b0);
        run(1);
        chk("R8", "force pulse at 80", force_idle, 1'b1);
        chk("R8", "flag with force", idle_flag, 1'b1);
        run(1);
        chk("R8", "force pulse ends", force_idle, 1'b0);
        clear_both();
        sda_in = 1'b0; run(1); sda_in = 1'b1;
        idle_sel = 2'd3;
        run(159);
        chk("R2", "code3 before 160", idle_flag, 1'b0);
        run(1);
        chk("R2", "code3 at 160", idle_flag, 1'b1);

        // R6: clear held through an expiry, set wins then clear acts
        new_phase("R6", 1);
        sda_in = 1'b0; run(1); sda_in = 1'b1;
        idle_sel = 2'd1;
        idle_flag_clr = 1'b1;
        run(40);
        chk("R6", "set beats clear", idle_flag, 1'b1);
        run(1);
        chk("R6", "clear after collision", idle_flag, 1'b0);
        idle_flag_clr = 1'b0;
        go_idle_en = 1'b0;

        // R2: code 0 is off
        new_phase("R2", 1);
        sda_in = 1'b0; run(1); sda_in = 1'b1;
        idle_sel = 2'd0;
        run(300);
        chk("R2", "idle code0 off", idle_flag, 1'b0);

        // R9: sparse ticks
        new_phase("R9", 3);
        idle_sel = 2'd1;
        sda_in = 1'b0; run(1); sda_in = 1'b1;
        phase_cyc = 0;
        run(117);
        chk("R9", "39 ticks in 117 cycles", idle_flag, 1'b0);
        run(1);
        chk("R9", "40th tick", idle_flag, 1'b1);
        clear_both();

        // R3 and R5: clock-low lengths
        new_phase("R3", 1);
        bus_busy = 1'b0; idle_sel = 2'd0;
        for (int c = 1; c <= 5; c++) begin
            scl_in = 1'b1; low_sel = 3'(c); run(2);
            scl_in = 1'b0;
            run(low_ticks(3'(c)) - 1);
            chk("R3", "clock-low before length", low_flag, 1'b0);
            run(1);
            chk("R3", "clock-low at length", low_flag, 1'b1);
            clear_both();
        end
        for (int c = 6; c <= 7; c++) begin
            scl_in = 1'b1; low_sel = 3'(c); run(2);
            scl_in = 1'b0;
            run(1100);
            chk("R3", "clock-low off code", low_flag, 1'b0);
        end

        new_phase("R5", 1);
        low_sel = 3'd1; scl_in = 1'b1; run(2);
        scl_in = 1'b0; bus_busy = 1'b1; sda_in = 1'b0;
        run(35);
        scl_in = 1'b1; run(1); scl_in = 1'b0;
        run(39);
        chk("R5", "restart on clock high", low_flag, 1'b0);
        run(1);
        chk("R5", "expiry regardless of busy", low_flag, 1'b1);
        run(100);
        chk("R7", "low watch no rearm", low_flag, 1'b1);
        chk("R5", "idle flag untouched", idle_flag, 1'b0);
        scl_in = 1'b1;
        run(5);

        summary();
    end

endmodule